// File: doc/BRIEF.md
# Interrupt Target Routing Register File

This block holds one 8-bit processor bitmap per interrupt line. Each bitmap names the processors that are allowed to take that interrupt. Software reaches the bitmaps through a simple register port. The byte offset of a bitmap equals its interrupt number. Either one byte or one aligned 32-bit word can be accessed at a time.

On every accepted write, the block works out one chosen processor for each bitmap that was written. The chosen processor is the lowest set bit of the new bitmap. The block drives these chosen indices to downstream routing logic, three bits per interrupt.

The first 32 interrupts are private to each processor, so their bitmaps cannot be written. Reading one of them returns the requester's own bit. Addresses beyond the configured interrupt count read as zero and ignore writes. The number of interrupts is a parameter and must be a multiple of 32.

Top module: `rt_route_regs`

## Requirements
- R1: A byte write (`req_size`=0) stores `req_wdata[7:0]` as the bitmap of interrupt `req_addr`. A byte read returns that interrupt's bitmap in `rsp_rdata[7:0]` with bits 31:8 zero.
- R2: A word access (`req_size`=1) ignores `req_addr[1:0]` and covers interrupts 4*(`req_addr`>>2)+k for k=0..3. Interrupt 4*(`req_addr`>>2)+k uses bits [8k+7:8k], so the lowest-numbered interrupt sits in the least significant byte.
- R3: Writes that address interrupts 0 to 31 change neither any stored bitmap nor any chosen target.
- R4: A read of an interrupt 0 to 31 returns the byte 1<<`req_cpu` in that interrupt's byte lane.
- R5: After a write to an interrupt i of 32 or above, `tgt_idx[3i+2:3i]` is the index of the lowest set bit of the new bitmap, or 0 if the bitmap is zero. The new value is visible from the clock edge that accepts the write. `tgt_idx` for interrupts 0 to 31 is always 0.
- R6: After reset, every writable bitmap reads as 0, every chosen target is 0, and `rsp_valid` is 0.
- R7: Reads at addresses of `NUM_IRQ` or more return 0, and writes to those addresses change no bitmap and no target.
- R8: A read accepted at a clock edge drives `rsp_valid`=1 with its data for exactly the following cycle. A write produces no response.
- R9: A chosen target changes only at an edge that accepts a write to that interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request, one per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte access, 1 = 32-bit access |
| req_addr | input | clog2(NUM_IRQ)+1 | Byte offset (equals interrupt number) |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 3 | Index of the requesting processor |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| tgt_idx | output | 3*NUM_IRQ | Chosen target index per interrupt |

## Verification
Read data and `rsp_valid` are registered, so both are due one clock after the edge that accepts the read. The chosen targets are also registered, and they change at the edge that accepts the write. The bench therefore drives each request on a falling edge and releases it on the next falling edge. It samples every output at that same falling edge, after exactly one rising edge. After each access it compares the whole `tgt_idx` vector against its model, so a target that moves on a read or an ignored write is caught in the cycle it happens.

// File: rtl/rt_route_pkg.sv
package rt_route_pkg;
  localparam int MAP_W     = 8;
  localparam int TGT_W     = 3;
  localparam int PRIV_IRQS = 32;

  typedef logic [MAP_W-1:0] map_t;
  typedef logic [TGT_W-1:0] tgt_t;

  // Index of the lowest set bit; zero map selects processor 0.
  function automatic tgt_t lowest_set(input map_t m);
    tgt_t r;
    r = '0;
    for (int b = MAP_W - 1; b >= 0; b--) begin
      if (m[b]) r = tgt_t'(b);
    end
    return r;
  endfunction

  // One-hot bitmap for a single processor.
  function automatic map_t cpu_bit(input tgt_t c);
    return map_t'(1) << c;
  endfunction
endpackage

// File: rtl/rt_wr_decode.sv
module rt_wr_decode
  import rt_route_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = $clog2(NUM_IRQ) + 1
) (
  input  logic                     wr_fire,
  input  logic                     req_size,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [31:0]              req_wdata,
  output logic [NUM_IRQ-1:0]       wr_en,
  output logic [NUM_IRQ*MAP_W-1:0] wr_map
);
  localparam int GRP_W = ADDR_W - 2;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    localparam int GRP  = i / 4;
    localparam int LANE = i % 4;
    logic hit_word;
    logic hit_byte;

    assign hit_word = req_size && (req_addr[ADDR_W-1:2] == GRP_W'(GRP));
    assign hit_byte = !req_size && (req_addr == ADDR_W'(i));
    assign wr_map[i*MAP_W +: MAP_W] = req_size ? req_wdata[LANE*MAP_W +: MAP_W]
                                               : req_wdata[MAP_W-1:0];
    if (i < PRIV_IRQS) begin : g_priv
      assign wr_en[i] = 1'b0;
    end else begin : g_shared
      assign wr_en[i] = wr_fire && (hit_word || hit_byte);
    end
  end
endmodule

// File: rtl/rt_entry.sv
module rt_entry
  import rt_route_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  map_t wr_map,
  output map_t map_q,
  output tgt_t tgt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      tgt_q <= '0;
    end else if (wr_en) begin
      map_q <= wr_map;
      tgt_q <= lowest_set(wr_map);
    end
  end
endmodule

// File: rtl/rt_rd_mux.sv
module rt_rd_mux
  import rt_route_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = $clog2(NUM_IRQ) + 1
) (
  input  logic                     req_size,
  input  logic [ADDR_W-1:0]        req_addr,
  input  tgt_t                     req_cpu,
  input  logic [NUM_IRQ*MAP_W-1:0] maps,
  output logic [31:0]              rdata
);
  function automatic map_t lookup(input logic [ADDR_W-1:0] idx, input tgt_t cpu,
                                  input logic [NUM_IRQ*MAP_W-1:0] m);
    map_t r;
    r = '0;
    if (idx >= ADDR_W'(NUM_IRQ)) r = '0;
    else if (idx < ADDR_W'(PRIV_IRQS)) r = cpu_bit(cpu);
    else r = m[int'(idx)*MAP_W +: MAP_W];
    return r;
  endfunction

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [ADDR_W-1:0] idx;
    logic              lane_on;
    assign idx     = req_size ? {req_addr[ADDR_W-1:2], 2'(k)} : req_addr;
    assign lane_on = req_size || (k == 0);
    assign rdata[k*MAP_W +: MAP_W] = lane_on ? lookup(idx, req_cpu, maps) : '0;
  end
endmodule

// File: rtl/rt_route_regs.sv
module rt_route_regs
  import rt_route_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  input  logic                               req_write,
  input  logic                               req_size,
  input  logic [$clog2(NUM_IRQ):0]           req_addr,
  input  logic [31:0]                        req_wdata,
  input  logic [2:0]                         req_cpu,
  output logic                               rsp_valid,
  output logic [31:0]                        rsp_rdata,
  output logic [NUM_IRQ*3-1:0]               tgt_idx
);
  localparam int ADDR_W = $clog2(NUM_IRQ) + 1;

  // Named internal events.
  logic                     wr_fire;
  logic                     rd_fire;
  logic [NUM_IRQ-1:0]       wr_en;
  logic [NUM_IRQ*MAP_W-1:0] wr_map;
  logic [NUM_IRQ*MAP_W-1:0] maps;
  logic [31:0]              rd_data;

  assign wr_fire = req_valid && req_write;
  assign rd_fire = req_valid && !req_write;

  rt_wr_decode #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) dec_i (
    .wr_fire  (wr_fire),
    .req_size (req_size),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .wr_en    (wr_en),
    .wr_map   (wr_map)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ent
    if (i < PRIV_IRQS) begin : g_priv
      assign maps[i*MAP_W +: MAP_W]    = '0;
      assign tgt_idx[i*TGT_W +: TGT_W] = '0;
    end else begin : g_shared
      rt_entry ent_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en[i]),
        .wr_map(wr_map[i*MAP_W +: MAP_W]),
        .map_q (maps[i*MAP_W +: MAP_W]),
        .tgt_q (tgt_idx[i*TGT_W +: TGT_W])
      );
    end
  end

  rt_rd_mux #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) mux_i (
    .req_size(req_size),
    .req_addr(req_addr),
    .req_cpu (req_cpu),
    .maps    (maps),
    .rdata   (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      rsp_rdata <= rd_fire ? rd_data : '0;
    end
  end
endmodule

// File: rtl/rt_route_regs_chk.sv
module rt_route_regs_chk #(
  parameter int NUM_IRQ = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_write,
  input logic                       req_size,
  input logic [$clog2(NUM_IRQ):0]   req_addr,
  input logic                       rsp_valid,
  input logic [31:0]                rsp_rdata,
  input logic [NUM_IRQ*3-1:0]       tgt_idx,
  input logic [NUM_IRQ-1:0]         wr_en
);
  localparam int ADDR_W = $clog2(NUM_IRQ) + 1;

  AST_READ_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid) else $error("AST_READ_RSP"); // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid) else $error("AST_NO_SPURIOUS_RSP"); // R8
  AST_TGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(tgt_idx)) else $error("AST_TGT_HOLD"); // R9
  AST_PRIV_READ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_size && req_addr < ADDR_W'(32))
      |=> ($countones(rsp_rdata) == 1)) else $error("AST_PRIV_READ_ONEHOT"); // R4
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr >= ADDR_W'(NUM_IRQ))
      |=> (rsp_rdata == 32'h0)) else $error("AST_OOR_READ_ZERO"); // R7
  AST_OOR_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr >= ADDR_W'(NUM_IRQ))
      |=> $stable(tgt_idx)) else $error("AST_OOR_WRITE_HOLD"); // R7
  AST_PRIV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr < ADDR_W'(32)) |-> (wr_en == '0))
    else $error("AST_PRIV_NO_WRITE"); // R3
endmodule

bind rt_route_regs rt_route_regs_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_size (req_size),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata),
  .tgt_idx  (tgt_idx),
  .wr_en    (wr_en)
);

// File: tb/rt_route_regs_tb_top.sv
module rt_route_regs_tb_top;
  localparam int N  = 64;
  localparam int AW = $clog2(N) + 1;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           req_valid = 0, req_write = 0, req_size = 0;
  logic [AW-1:0]  req_addr = '0;
  logic [31:0]    req_wdata = '0;
  logic [2:0]     req_cpu = '0;
  logic           rsp_valid;
  logic [31:0]    rsp_rdata;
  logic [N*3-1:0] tgt_idx;

  int n_tests = 0, n_fail = 0;
  logic [7:0] m_map [N];
  logic [2:0] m_tgt [N];

  always #10 clk = ~clk;

  rt_route_regs #(.NUM_IRQ(N)) dut_i (.*);

  function automatic logic [2:0] first_one(input logic [7:0] v);
    int b = 0;
    while (b < 8 && !v[b]) b++;
    return (b == 8) ? 3'd0 : 3'(b);
  endfunction

  function automatic logic [7:0] model_byte(input int irq, input logic [2:0] cpu);
    if (irq >= N) return 8'h00;
    if (irq < 32) return 8'h01 << cpu;
    return m_map[irq];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_tgts(input string req);
    bit ok = 1;
    int bad = 0;
    for (int i = 0; i < N; i++) begin
      if (tgt_idx[i*3 +: 3] !== m_tgt[i]) begin ok = 0; bad = i; end
    end
    check(ok, req, 32'(tgt_idx[bad*3 +: 3]), 32'(m_tgt[bad]));
  endtask

  task automatic access(input bit wr, input bit sz, input int addr,
                        input logic [31:0] wd, input logic [2:0] cpu);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz;
    req_addr = AW'(addr); req_wdata = wd; req_cpu = cpu;
    if (wr) begin
      for (int k = 0; k < (sz ? 4 : 1); k++) begin
        int irq = sz ? ((addr / 4) * 4 + k) : addr;
        logic [7:0] b = sz ? wd[k*8 +: 8] : wd[7:0];
        if (irq >= 32 && irq < N) begin
          m_map[irq] = b;
          m_tgt[irq] = first_one(b);
        end
      end
    end
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic read_check(input bit sz, input int addr, input logic [2:0] cpu, input string req);
    logic [31:0] exp = '0;
    access(0, sz, addr, '0, cpu);
    for (int k = 0; k < (sz ? 4 : 1); k++)
      exp[k*8 +: 8] = model_byte(sz ? ((addr / 4) * 4 + k) : addr, cpu);
    check(rsp_valid === 1'b1, {req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check(rsp_rdata === exp, req, rsp_rdata, exp);
    check_tgts({req, " R9 targets unchanged by read"});
  endtask

  task automatic t_reset();
    check(rsp_valid === 1'b0, "R6 rsp_valid after reset", 32'(rsp_valid), 0);
    check_tgts("R6 targets zero after reset");
    read_check(1, 32, 3'd0, "R6 bitmaps zero after reset");
    read_check(1, 60, 3'd0, "R6 bitmaps zero after reset");
  endtask

  task automatic t_byte();
    access(1, 0, 40, 32'hFFFF_FF28, 3'd0);
    check_tgts("R5 lowest bit of 0x28");
    read_check(0, 40, 3'd0, "R1 byte read back");
    access(1, 0, 33, 32'h0000_0080, 3'd0);
    check_tgts("R5 bit7 selects target 7");
    access(1, 0, 40, 32'h0000_0000, 3'd0);
    check_tgts("R5 zero map selects target 0");
    read_check(0, 40, 3'd0, "R1 byte write of zero");
  endtask

  task automatic t_word();
    access(1, 1, 48, 32'h0180_0C06, 3'd0);
    check_tgts("R2 R5 word write lanes");
    read_check(1, 50, 3'd0, "R2 word read ignores addr low bits");
    read_check(0, 50, 3'd0, "R2 byte read of lane 2");
    access(1, 1, 63, 32'hA5FF_10C0, 3'd0);
    check_tgts("R2 word write last group");
    read_check(1, 60, 3'd0, "R2 last group read");
  endtask

  task automatic t_priv();
    access(1, 1, 4, 32'hFFFF_FFFF, 3'd0);
    check_tgts("R3 private word write ignored");
    access(1, 0, 31, 32'h0000_0010, 3'd0);
    check_tgts("R3 private byte write ignored");
    read_check(0, 5, 3'd3, "R4 private byte read cpu3");
    read_check(1, 8, 3'd6, "R4 private word read cpu6");
    read_check(0, 31, 3'd7, "R3 R4 private read after write");
  endtask

  task automatic t_oor();
    access(1, 1, 64, 32'h1122_3344, 3'd0);
    access(1, 0, 100, 32'h0000_0002, 3'd0);
    check_tgts("R7 out-of-range writes ignored");
    read_check(1, 64, 3'd0, "R7 out-of-range word read");
    read_check(0, 127, 3'd2, "R7 out-of-range byte read");
    read_check(1, 48, 3'd0, "R7 in-range data kept");
  endtask

  task automatic t_rsp();
    access(1, 0, 45, 32'h0000_0044, 3'd0);
    check(rsp_valid === 1'b0, "R8 no response to write", 32'(rsp_valid), 0);
    read_check(0, 45, 3'd0, "R8 read response");
    @(negedge clk);
    check(rsp_valid === 1'b0, "R8 response lasts one cycle", 32'(rsp_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_map[i] = '0; m_tgt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_byte();
    t_word();
    t_priv();
    t_oor();
    t_rsp();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule